// File: doc/BRIEF.md
# Banked Interrupt Controller with Shortcuts

This block collects 72 level-sensitive interrupt sources into three banks: a basic bank of 8 sources and two general banks of 32 sources each. Each bank keeps an enable mask that software sets through a write-one-to-set register and clears through a write-one-to-clear register. A source is pending while its input is high and its enable bit is set. Nothing is latched, so a source stops being pending as soon as its input falls.

The basic bank's pending word is the first place a handler looks. It holds the basic-bank sources, one summary bit per general bank, and a set of shortcut bits. Each shortcut bit mirrors one selected general-bank source, so the handler finds that source without a second read. A shortcut source does not raise its bank's summary bit, and it can be masked only in its own bank.

A routing register picks any one of the 72 sources by a flat index and sends it to a separate fast-interrupt line. While routing is on, that source is kept off the normal interrupt line. Software reaches every register through a simple valid/write/address/data port. Read data comes back one cycle after the request.

Top module: `intc_banked_top`

## Requirements
- R1: After reset, all three enable masks and the routing register are zero, and `irq_o` and `fiq_o` are low.
- R2: A write to an enable register ORs the write data into that bank's mask. A write to a disable register clears the mask bits where the data has ones. Bank 1 uses 0x10 and 0x1C, bank 2 uses 0x14 and 0x20, and the basic bank uses 0x18 and 0x24. Both registers of a bank read back the current mask.
- R3: The pending registers are read-only. They are the basic word at 0x00, bank 1 at 0x04 and bank 2 at 0x08. A bank pending register reads as source AND enable. Writes to 0x00, 0x04 and 0x08 change no state.
- R4: In the basic word, bits 7:0 are the enabled basic sources. Bit 8 is set while any enabled bank 1 source that is not a shortcut is pending, and bit 9 does the same for bank 2. Shortcut sources never set bit 8 or bit 9. Bits 31:21 read as zero.
- R5: Basic word bits 10 to 14 mirror the enabled bank 1 sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 mirror the enabled bank 2 sources 21, 22, 23, 24, 25 and 30, in that order.
- R6: The basic enable mask holds only 8 bits. Its enable and disable registers read back zero in bits 31:8. Writing the basic enable or disable registers has no effect on the summary bits or the shortcut bits. A shortcut bit follows only its own bank's mask.
- R7: The routing register sits at 0x0C. Bits 6:0 hold the flat source index and bit 7 is the routing enable. A write stores data bits 7:0, and bits 31:8 read as zero.
- R8: The flat index numbers bank 1 sources 0 to 31, bank 2 sources 32 to 63 and basic sources 64 to 71. One cycle after the inputs, `fiq_o` equals routing enable AND the raw level of the indexed source. This holds whatever the enable masks are. An index of 72 or more keeps `fiq_o` low.
- R9: One cycle after the inputs, `irq_o` is high exactly when some enabled source is pending, not counting the routed source while routing is enabled.
- R10: A read request gives `rsp_valid_o` high one cycle later, with the register value in `rsp_rdata_o`. Reads of any address other than the ten register offsets return zero, and that includes unaligned addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (8) | Byte address of the register |
| req_wdata_i | input | DATA_W (32) | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | DATA_W (32) | Read data |
| src_basic_i | input | BASIC_N (8) | Basic-bank source levels |
| src_bank1_i | input | GEN_N (32) | Bank 1 source levels |
| src_bank2_i | input | GEN_N (32) | Bank 2 source levels |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The bench builds the block with its default parameters: 8 basic sources, 32 sources per general bank, an 8-bit address and a 32-bit data word. These values are the only ones that put every shortcut position, both summary bits and the full 72-entry flat routing index in reach, so every shortcut and every routing target can be driven. Random routing indices up to 79 also reach the out-of-range region above 71. Random masks and source levels then mix shortcut and non-shortcut sources in the same bank, which is where summary suppression and bank-only masking can go wrong.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // register byte offsets
   localparam int OFF_PEND_BASIC = 'h00;
   localparam int OFF_PEND_B1    = 'h04;
   localparam int OFF_PEND_B2    = 'h08;
   localparam int OFF_FIQ_CTRL   = 'h0C;
   localparam int OFF_EN_B1      = 'h10;
   localparam int OFF_EN_B2      = 'h14;
   localparam int OFF_EN_BASIC   = 'h18;
   localparam int OFF_DIS_B1     = 'h1C;
   localparam int OFF_DIS_B2     = 'h20;
   localparam int OFF_DIS_BASIC  = 'h24;

   // shortcut tables: general-bank source number per shortcut slot
   localparam int SC1_CNT = 5;
   localparam int SC2_CNT = 6;
   localparam int SC1_SRC [SC1_CNT] = '{7, 9, 10, 18, 19};
   localparam int SC2_SRC [SC2_CNT] = '{21, 22, 23, 24, 25, 30};

   // routing register layout
   localparam int FIQ_IDX_W  = 7;
   localparam int FIQ_CTRL_W = FIQ_IDX_W + 1;

   typedef enum logic [3:0] {
      RS_NONE,
      RS_PEND0,
      RS_PEND1,
      RS_PEND2,
      RS_FIQ,
      RS_EN1,
      RS_EN2,
      RS_EN0,
      RS_DIS1,
      RS_DIS2,
      RS_DIS0
   } reg_sel_e;

endpackage

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
   parameter int N = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] en_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o <= '0;
      end else if (set_i) begin
         en_o <= en_o | bits_i;
      end else if (clr_i) begin
         en_o <= en_o & ~bits_i;
      end
   end

endmodule

// File: rtl/intc_summary.sv
module intc_summary
   import intc_pkg::*;
#(
   parameter int BASIC_N = 8,
   parameter int GEN_N   = 32,
   parameter int DATA_W  = 32
) (
   input  logic [BASIC_N-1:0] pend0_i,
   input  logic [GEN_N-1:0]   pend1_i,
   input  logic [GEN_N-1:0]   pend2_i,
   output logic [DATA_W-1:0]  word_o
);

   localparam int SUM1_POS = BASIC_N;
   localparam int SUM2_POS = BASIC_N + 1;
   localparam int SC1_BASE = BASIC_N + 2;
   localparam int SC2_BASE = SC1_BASE + SC1_CNT;

   logic [GEN_N-1:0] plain1;
   logic [GEN_N-1:0] plain2;

   // sources without a shortcut feed the bank summary bits
   always_comb begin
      plain1 = pend1_i;
      plain2 = pend2_i;
      for (int i = 0; i < SC1_CNT; i++) plain1[SC1_SRC[i]] = 1'b0;
      for (int j = 0; j < SC2_CNT; j++) plain2[SC2_SRC[j]] = 1'b0;
   end

   always_comb begin
      word_o                   = '0;
      word_o[BASIC_N-1:0]      = pend0_i;
      word_o[SUM1_POS]         = |plain1;
      word_o[SUM2_POS]         = |plain2;
      for (int i = 0; i < SC1_CNT; i++) word_o[SC1_BASE+i] = pend1_i[SC1_SRC[i]];
      for (int j = 0; j < SC2_CNT; j++) word_o[SC2_BASE+j] = pend2_i[SC2_SRC[j]];
   end

endmodule

// File: rtl/intc_fiq_route.sv
module intc_fiq_route #(
   parameter int TOTAL = 72,
   parameter int IDX_W = 7
) (
   input  logic [TOTAL-1:0] raw_i,
   input  logic [IDX_W-1:0] sel_i,
   input  logic             en_i,
   output logic [TOTAL-1:0] route_mask_o,
   output logic             fiq_o
);

   for (genvar k = 0; k < TOTAL; k++) begin : g_tap
      assign route_mask_o[k] = en_i && (sel_i == IDX_W'(k));
   end

   assign fiq_o = |(route_mask_o & raw_i);

endmodule

// File: rtl/intc_banked_top.sv
module intc_banked_top
   import intc_pkg::*;
#(
   parameter int BASIC_N = 8,
   parameter int GEN_N   = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   output logic               rsp_valid_o,
   output logic [DATA_W-1:0]  rsp_rdata_o,
   input  logic [BASIC_N-1:0] src_basic_i,
   input  logic [GEN_N-1:0]   src_bank1_i,
   input  logic [GEN_N-1:0]   src_bank2_i,
   output logic               irq_o,
   output logic               fiq_o
);

   localparam int TOTAL = 2 * GEN_N + BASIC_N;

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data_w
      $error("intc_banked_top: DATA_W must be 32");
   end
   if (GEN_N < 31 || GEN_N > DATA_W) begin : g_bad_gen_n
      $error("intc_banked_top: GEN_N must cover source 30 and fit a word");
   end
   if (BASIC_N < 1 || BASIC_N + 2 + SC1_CNT + SC2_CNT > DATA_W) begin : g_bad_basic_n
      $error("intc_banked_top: basic word does not fit DATA_W");
   end
   if (TOTAL > (1 << FIQ_IDX_W)) begin : g_bad_total
      $error("intc_banked_top: flat index field too narrow");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("intc_banked_top: ADDR_W too small for register map");
   end

   // address decode
   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      reg_sel_e s;
      s = RS_NONE;
      if (a == ADDR_W'(OFF_PEND_BASIC)) s = RS_PEND0;
      if (a == ADDR_W'(OFF_PEND_B1))    s = RS_PEND1;
      if (a == ADDR_W'(OFF_PEND_B2))    s = RS_PEND2;
      if (a == ADDR_W'(OFF_FIQ_CTRL))   s = RS_FIQ;
      if (a == ADDR_W'(OFF_EN_B1))      s = RS_EN1;
      if (a == ADDR_W'(OFF_EN_B2))      s = RS_EN2;
      if (a == ADDR_W'(OFF_EN_BASIC))   s = RS_EN0;
      if (a == ADDR_W'(OFF_DIS_B1))     s = RS_DIS1;
      if (a == ADDR_W'(OFF_DIS_B2))     s = RS_DIS2;
      if (a == ADDR_W'(OFF_DIS_BASIC))  s = RS_DIS0;
      return s;
   endfunction

   reg_sel_e sel;
   logic     wr_go;
   logic     rd_go;

   assign sel   = decode(req_addr_i);
   assign wr_go = req_valid_i && req_write_i;
   assign rd_go = req_valid_i && !req_write_i;

   // enable masks
   logic [BASIC_N-1:0] en0_q;
   logic [GEN_N-1:0]   en1_q;
   logic [GEN_N-1:0]   en2_q;

   intc_enable_bank #(.N(BASIC_N)) u_en0 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr_go && sel == RS_EN0),
      .clr_i  (wr_go && sel == RS_DIS0),
      .bits_i (req_wdata_i[BASIC_N-1:0]),
      .en_o   (en0_q)
   );

   intc_enable_bank #(.N(GEN_N)) u_en1 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr_go && sel == RS_EN1),
      .clr_i  (wr_go && sel == RS_DIS1),
      .bits_i (req_wdata_i[GEN_N-1:0]),
      .en_o   (en1_q)
   );

   intc_enable_bank #(.N(GEN_N)) u_en2 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr_go && sel == RS_EN2),
      .clr_i  (wr_go && sel == RS_DIS2),
      .bits_i (req_wdata_i[GEN_N-1:0]),
      .en_o   (en2_q)
   );

   // routing register
   logic [FIQ_CTRL_W-1:0] fiq_ctrl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fiq_ctrl_q <= '0;
      end else if (wr_go && sel == RS_FIQ) begin
         fiq_ctrl_q <= req_wdata_i[FIQ_CTRL_W-1:0];
      end
   end

   // masked pending and basic word
   logic [BASIC_N-1:0] pend0;
   logic [GEN_N-1:0]   pend1;
   logic [GEN_N-1:0]   pend2;
   logic [DATA_W-1:0]  basic_word;

   assign pend0 = src_basic_i & en0_q;
   assign pend1 = src_bank1_i & en1_q;
   assign pend2 = src_bank2_i & en2_q;

   intc_summary #(
      .BASIC_N (BASIC_N),
      .GEN_N   (GEN_N),
      .DATA_W  (DATA_W)
   ) u_summary (
      .pend0_i (pend0),
      .pend1_i (pend1),
      .pend2_i (pend2),
      .word_o  (basic_word)
   );

   // fast-interrupt routing over the flat index
   logic [TOTAL-1:0] raw_all;
   logic [TOTAL-1:0] pend_all;
   logic [TOTAL-1:0] route_mask;
   logic             fiq_d;

   assign raw_all  = {src_basic_i, src_bank2_i, src_bank1_i};
   assign pend_all = {pend0, pend2, pend1};

   intc_fiq_route #(
      .TOTAL (TOTAL),
      .IDX_W (FIQ_IDX_W)
   ) u_route (
      .raw_i        (raw_all),
      .sel_i        (fiq_ctrl_q[FIQ_IDX_W-1:0]),
      .en_i         (fiq_ctrl_q[FIQ_IDX_W]),
      .route_mask_o (route_mask),
      .fiq_o        (fiq_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_o <= 1'b0;
         fiq_o <= 1'b0;
      end else begin
         irq_o <= |(pend_all & ~route_mask);
         fiq_o <= fiq_d;
      end
   end

   // read path
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      unique case (sel)
         RS_PEND0:        rd_mux = basic_word;
         RS_PEND1:        rd_mux = DATA_W'(pend1);
         RS_PEND2:        rd_mux = DATA_W'(pend2);
         RS_FIQ:          rd_mux = DATA_W'(fiq_ctrl_q);
         RS_EN1, RS_DIS1: rd_mux = DATA_W'(en1_q);
         RS_EN2, RS_DIS2: rd_mux = DATA_W'(en2_q);
         RS_EN0, RS_DIS0: rd_mux = DATA_W'(en0_q);
         default:         rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= rd_go;
         if (rd_go) rsp_rdata_o <= rd_mux;
      end
   end

endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk #(
   parameter int BASIC_N = 8,
   parameter int GEN_N   = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_valid_i,
   input logic               req_write_i,
   input logic [ADDR_W-1:0]  req_addr_i,
   input logic [DATA_W-1:0]  req_wdata_i,
   input logic               rsp_valid_o,
   input logic [BASIC_N-1:0] src_basic_i,
   input logic [GEN_N-1:0]   src_bank1_i,
   input logic [GEN_N-1:0]   src_bank2_i,
   input logic               irq_o,
   input logic               fiq_o,
   input logic [GEN_N-1:0]   en1_q
);

   logic quiet;
   logic wr_en1;
   logic wr_dis1;

   assign quiet   = (src_basic_i == '0) && (src_bank1_i == '0) && (src_bank2_i == '0);
   assign wr_en1  = req_valid_i && req_write_i && (req_addr_i == ADDR_W'('h10));
   assign wr_dis1 = req_valid_i && req_write_i && (req_addr_i == ADDR_W'('h1C));

   // R1: outputs held low while reset is active
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         assert_reset_quiet_R1: assert (!irq_o && !fiq_o && !rsp_valid_o)
            else $error("outputs active during reset");
      end
   end

   // R2
   assert_enable_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en1 |=> ((en1_q & $past(req_wdata_i[GEN_N-1:0])) == $past(req_wdata_i[GEN_N-1:0])));

   // R2
   assert_disable_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_dis1 |=> ((en1_q & $past(req_wdata_i[GEN_N-1:0])) == '0));

   // R8
   assert_fiq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      quiet |=> !fiq_o);

   // R9
   assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      quiet |=> !irq_o);

   // R10
   assert_read_answers_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !req_write_i) |=> rsp_valid_o);

   // R10
   assert_no_stray_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

endmodule

bind intc_banked_top intc_banked_chk #(
   .BASIC_N (BASIC_N),
   .GEN_N   (GEN_N),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_write_i (req_write_i),
   .req_addr_i  (req_addr_i),
   .req_wdata_i (req_wdata_i),
   .rsp_valid_o (rsp_valid_o),
   .src_basic_i (src_basic_i),
   .src_bank1_i (src_bank1_i),
   .src_bank2_i (src_bank2_i),
   .irq_o       (irq_o),
   .fiq_o       (fiq_o),
   .en1_q       (en1_q)
);

// File: tb/intc_banked_top_tb.sv
module intc_banked_top_tb;

   logic        clk;
   logic        rst_n;
   logic        req_valid;
   logic        req_write;
   logic [7:0]  req_addr;
   logic [31:0] req_wdata;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [7:0]  s0;
   logic [31:0] s1;
   logic [31:0] s2;
   logic        irq;
   logic        fiq;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic [7:0]  m_en0;
   logic [31:0] m_en1;
   logic [31:0] m_en2;
   logic [7:0]  m_fiq;

   intc_banked_top u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_write_i (req_write),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .rsp_valid_o (rsp_valid),
      .rsp_rdata_o (rsp_rdata),
      .src_basic_i (s0),
      .src_bank1_i (s1),
      .src_bank2_i (s2),
      .irq_o       (irq),
      .fiq_o       (fiq)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   function automatic logic [31:0] f_basic();
      logic [31:0] w;
      logic [31:0] p1;
      logic [31:0] p2;
      p1 = s1 & m_en1;
      p2 = s2 & m_en2;
      w = '0;
      w[7:0] = s0 & m_en0;
      w[8]  = |(p1 & ~32'h000C_0680);
      w[9]  = |(p2 & ~32'h43E0_0000);
      w[10] = p1[7];
      w[11] = p1[9];
      w[12] = p1[10];
      w[13] = p1[18];
      w[14] = p1[19];
      w[15] = p2[21];
      w[16] = p2[22];
      w[17] = p2[23];
      w[18] = p2[24];
      w[19] = p2[25];
      w[20] = p2[30];
      return w;
   endfunction

   function automatic logic [31:0] f_read(input logic [7:0] a);
      case (a)
         8'h00: return f_basic();
         8'h04: return s1 & m_en1;
         8'h08: return s2 & m_en2;
         8'h0C: return {24'h0, m_fiq};
         8'h10, 8'h1C: return m_en1;
         8'h14, 8'h20: return m_en2;
         8'h18, 8'h24: return {24'h0, m_en0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [71:0] f_route();
      logic [71:0] r;
      r = '0;
      if (m_fiq[7] && m_fiq[6:0] < 7'd72) r[m_fiq[6:0]] = 1'b1;
      return r;
   endfunction

   function automatic logic f_fiq();
      return |(f_route() & {s0, s2, s1});
   endfunction

   function automatic logic f_irq();
      return |({s0 & m_en0, s2 & m_en2, s1 & m_en1} & ~f_route());
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = a;
      req_wdata = d;
      @(posedge clk);
      case (a)
         8'h10: m_en1 = m_en1 | d;
         8'h14: m_en2 = m_en2 | d;
         8'h18: m_en0 = m_en0 | d[7:0];
         8'h1C: m_en1 = m_en1 & ~d;
         8'h20: m_en2 = m_en2 & ~d;
         8'h24: m_en0 = m_en0 & ~d[7:0];
         8'h0C: m_fiq = d[7:0];
         default: ;
      endcase
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      logic [31:0] exp;
      exp = f_read(a);
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      check({tag, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
      check({tag, " rdata"}, rsp_rdata, exp);
      req_valid = 1'b0;
   endtask

   task automatic chk_out(input string tag);
      logic ei;
      logic ef;
      ei = f_irq();
      ef = f_fiq();
      @(posedge clk);
      @(negedge clk);
      check({tag, " irq"}, {31'h0, irq}, {31'h0, ei});
      check({tag, " fiq"}, {31'h0, fiq}, {31'h0, ef});
   endtask

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h00: return "R4";
         8'h04, 8'h08: return "R3";
         8'h0C: return "R7";
         8'h18, 8'h24: return "R6";
         8'h10, 8'h14, 8'h1C, 8'h20: return "R2";
         default: return "R10";
      endcase
   endfunction

   // watchdog
   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] regs [10];
      regs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
      void'($urandom(32'd20240611));
      m_en0 = '0; m_en1 = '0; m_en2 = '0; m_fiq = '0;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0;
      s0 = 8'hFF; s1 = '1; s2 = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 irq in reset", {31'h0, irq}, 32'h0);
      check("R1 fiq in reset", {31'h0, fiq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h10, "R1 en1");
      rd(8'h14, "R1 en2");
      rd(8'h18, "R1 en0");
      rd(8'h0C, "R1 route");
      chk_out("R1 idle");

      // R2 set / clear
      s0 = '0; s1 = '0; s2 = '0;
      wr(8'h10, 32'h0000_00F0);
      wr(8'h10, 32'h0000_0F00);
      rd(8'h10, "R2 en1 after sets");
      wr(8'h1C, 32'h0000_0030);
      rd(8'h1C, "R2 en1 via disable");
      check("R2 model", m_en1, 32'h0000_0FC0);

      // R3 pending read-only
      s1 = 32'hFFFF_FFFF;
      rd(8'h04, "R3 pend1");
      wr(8'h04, 32'h0);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h04, "R3 pend1 after write");
      rd(8'h10, "R3 en1 untouched");

      // R4 / R5 summary and shortcut positions
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      s1 = 32'h0000_0080;
      rd(8'h00, "R5 bank1 src7 shortcut");
      check("R4 bit8 suppressed", f_basic() & 32'h100, 32'h0);
      s1 = 32'h0000_0081;
      rd(8'h00, "R4 bank1 summary");
      s1 = '0; s2 = 32'h4000_0000;
      rd(8'h00, "R5 bank2 src30 shortcut");
      s2 = 32'h4000_0001;
      rd(8'h00, "R4 bank2 summary");
      s1 = 32'h000C_0680; s2 = 32'h43E0_0000;
      rd(8'h00, "R5 all shortcuts");
      chk_out("R9 shortcuts only");

      // R6 basic registers do not reach shortcuts
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, "R6 basic en width");
      wr(8'h24, 32'hFFFF_FF00);
      rd(8'h00, "R6 shortcut survives basic disable");
      wr(8'h1C, 32'h0000_0080);
      rd(8'h00, "R6 shortcut masked in bank");

      // R7 routing register
      wr(8'h0C, 32'hFFFF_FF85);
      rd(8'h0C, "R7 route readback");

      // R8 / R9 routing
      s0 = '0; s1 = 32'h0000_0020; s2 = '0;
      wr(8'h1C, 32'hFFFF_FFFF);
      chk_out("R8 raw source routed");
      wr(8'h10, 32'h0000_0020);
      chk_out("R9 routed source kept off irq");
      wr(8'h0C, 32'h0000_0005);
      chk_out("R9 route disabled");
      s1 = '0; s0 = 8'h04;
      wr(8'h0C, 32'h0000_00C2);
      chk_out("R8 basic index 66");
      wr(8'h0C, 32'h0000_00E4);
      s0 = 8'hFF; s1 = '1; s2 = '1;
      chk_out("R8 index 100 out of range");

      // R10 unmapped reads
      rd(8'h28, "R10 unmapped");
      rd(8'h02, "R10 unaligned");

      // random phase
      for (int it = 0; it < 400; it++) begin
         logic [7:0]  a;
         logic [31:0] d;
         s0 = 8'($urandom);
         s1 = $urandom & $urandom;
         s2 = $urandom & $urandom;
         a = regs[$urandom_range(9, 0)];
         d = $urandom;
         if (a == 8'h0C) d = {24'h0, 1'($urandom), 7'($urandom_range(79, 0))};
         wr(a, d);
         a = regs[$urandom_range(9, 0)];
         rd(a, {tag_of(a), " random"});
         chk_out("R9 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule